// File: doc/BRIEF.md
# Single-Wire Bus Master Control Front End

This block is the register-mapped front end of a master for a single-wire serial bus. Software programs it through a small register bus: a byte address, write and read strobes, write data and combinational read data. One start bit in the control word launches every operation. The other control bits choose which operation runs. With the init bit set it runs a line break with a presence sample. With the direction bit set it receives. Otherwise it transmits. The single-bit flag shortens any of the data operations to one slot. The start bit reads back as one while the operation runs and returns to zero on its own when the operation finishes.

Completion events are latched in an interrupt status register, which a read of that register clears. One interrupt output follows the latched bits when the enable bit in the control word is set. The bit-slot engine behind the registers is a stub with fixed cycle counts. The slave's reply is presented on three input pins: presence, answer and the reply byte. Each finished transmission is shown on a byte output with a one-cycle valid pulse.

The controlling state machine has four states. S_IDLE is the rest state. S_XMIT, S_RECV and S_BRK run a transmit, a receive and a break. The machine leaves S_IDLE for S_BRK when a start write carries init. It leaves for S_RECV when the start write carries direction, and for S_XMIT otherwise. Every active state returns to S_IDLE on the cycle its slot timer expires.

Top module: `swb_regfront`

## Requirements
- R1: After reset, the transmit data, receive data, control and interrupt status registers all read 0x00, and `irq` is low.
- R2: Byte address 0x00 reads `{REV_MAJOR, REV_MINOR}`, which is 0x21 by default.
- R3: The control register is at byte address 0x0C. Its bits are: 7 single-bit, 6 interrupt enable, 5 clock enable, 4 start (busy on read), 3 presence (read-only), 2 init, 1 direction (1 = receive) and 0 mode. A write to address 0x0C with start and clock enable set, and init and direction clear, transmits the byte at address 0x04. The transmission takes 8*SLOT_CYC cycles. When it ends, `sent_data` shows the byte for one cycle with `sent_valid` high, status bit 2 is set, and bit 4 reads 0 again.
- R4: A start write with direction set and init clear receives. If `dev_answer` is high when it ends, `dev_data` is stored at byte address 0x08 and status bit 1 is set.
- R5: If `dev_answer` is low when a receive ends, status bit 0 (timeout) is set and the receive data register keeps its value.
- R6: A start write with init set runs a break of BREAK_CYC cycles. This applies whatever the direction and single-bit flags are. At the end, status bit 0 is set, control bit 3 takes the value of `dev_present`, and bits 2 and 4 read 0.
- R7: With the single-bit flag set, an operation lasts SLOT_CYC cycles and only bit 0 moves. A transmission presents `{7'b0, tx[0]}` and a receive stores `{7'b0, dev_data[0]}`.
- R8: The interrupt status register at byte address 0x10 reads back the latched bits and clears them on that read. A completion event in the same cycle as the read stays latched.
- R9: `irq` is high exactly when control bit 6 is set and at least one status bit is latched.
- R10: While an operation is active, a control write is ignored in full. No field changes, and the running operation is neither restarted nor lengthened.
- R11: A start write with clock enable clear stores its fields but starts nothing, and bit 4 stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register byte address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (needed for the status clear-on-read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |
| dev_present | input | 1 | Slave answered the break |
| dev_answer | input | 1 | Slave answered the receive |
| dev_data | input | 8 | Byte sent by the slave |
| sent_data | output | 8 | Byte that a finished transmission put on the line |
| sent_valid | output | 1 | One-cycle pulse marking `sent_data` |

## Verification
The bench runs a behavioural model next to the design and compares every cycle, so any error in how long an operation takes shows up as a busy flag or interrupt one cycle early or late. It reads the status register on every cycle while a transmission is running. This forces the case where a read-clear and a completion event fall on the same edge; a design that lets the clear win would lose the completion and never raise `irq`. It rewrites the control word in the middle of a transmission. A design that accepts that write would restart the timer or change the flags, and `sent_valid` would then arrive late or carry the wrong byte. Finally, breaks with and without a slave present, and a start with clock enable clear, expose a presence bit that is not captured at the end of the break and a stray start.

// File: rtl/swb_pkg.sv
package swb_pkg;
    localparam logic [4:0] A_REV  = 5'h00;
    localparam logic [4:0] A_TXD  = 5'h04;
    localparam logic [4:0] A_RXD  = 5'h08;
    localparam logic [4:0] A_CTL  = 5'h0C;
    localparam logic [4:0] A_IST  = 5'h10;

    localparam int B_SINGLE = 7;
    localparam int B_IEN    = 6;
    localparam int B_CE     = 5;
    localparam int B_GO     = 4;
    localparam int B_PRES   = 3;
    localparam int B_INIT   = 2;
    localparam int B_DIR    = 1;
    localparam int B_MODE   = 0;

    localparam int IS_TX = 2;
    localparam int IS_RX = 1;
    localparam int IS_TO = 0;

    typedef enum logic [1:0] {
        S_IDLE,
        S_XMIT,
        S_RECV,
        S_BRK
    } swb_state_t;
endpackage

// File: rtl/swb_timer.sv
module swb_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic          run_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (load && !run_q) begin
            run_q <= 1'b1;
            cnt_q <= len - CW'(1);
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = run_q && (cnt_q == '0);

    // R10
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !done && load) |=> (run_q && cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/swb_seq.sv
module swb_seq
    import swb_pkg::*;
#(
    parameter int SLOT_CYC  = 4,
    parameter int BREAK_CYC = 10,
    parameter int CW        = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       tx_we,
    input  logic [7:0] wdata,
    input  logic       dev_present,
    input  logic       dev_answer,
    input  logic [7:0] dev_data,
    output logic [7:0] ctrl_rd,
    output logic [7:0] tx_q,
    output logic [7:0] rx_q,
    output logic [2:0] set_bits,
    output logic [7:0] sent_data,
    output logic       sent_valid,
    output logic       irq_en
);
    localparam int BYTE_CYC = 8 * SLOT_CYC;

    swb_state_t st_q, st_d;
    logic single_q, ce_q, init_q, dir_q, mode_q, pres_q;
    logic [7:0] sh_q;
    logic go_start, tmr_done;
    logic [CW-1:0] len_d;
    logic unused_pres_wr;

    assign unused_pres_wr = wdata[B_PRES];

    assign go_start = ctrl_we && (st_q == S_IDLE) && wdata[B_GO] && wdata[B_CE];

    always_comb begin
        if (wdata[B_INIT])        len_d = CW'(BREAK_CYC);
        else if (wdata[B_SINGLE]) len_d = CW'(SLOT_CYC);
        else                      len_d = CW'(BYTE_CYC);
    end

    swb_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go_start),
        .len   (len_d),
        .done  (tmr_done)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (go_start) begin
                    if (wdata[B_INIT])     st_d = S_BRK;
                    else if (wdata[B_DIR]) st_d = S_RECV;
                    else                   st_d = S_XMIT;
                end
            end
            S_XMIT, S_RECV, S_BRK: begin
                if (tmr_done) st_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // completion events for the status latch
    always_comb begin
        set_bits = 3'b000;
        if (tmr_done) begin
            unique case (st_q)
                S_XMIT:  set_bits[IS_TX] = 1'b1;
                S_RECV:  begin
                    if (dev_answer) set_bits[IS_RX] = 1'b1;
                    else            set_bits[IS_TO] = 1'b1;
                end
                S_BRK:   set_bits[IS_TO] = 1'b1;
                default: set_bits = 3'b000;
            endcase
        end
    end

    // register and data outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            single_q   <= 1'b0;
            irq_en     <= 1'b0;
            ce_q       <= 1'b0;
            init_q     <= 1'b0;
            dir_q      <= 1'b0;
            mode_q     <= 1'b0;
            pres_q     <= 1'b0;
            tx_q       <= 8'h00;
            rx_q       <= 8'h00;
            sh_q       <= 8'h00;
            sent_data  <= 8'h00;
            sent_valid <= 1'b0;
        end else begin
            sent_valid <= 1'b0;
            if (ctrl_we && st_q == S_IDLE) begin
                single_q <= wdata[B_SINGLE];
                irq_en   <= wdata[B_IEN];
                ce_q     <= wdata[B_CE];
                init_q   <= wdata[B_INIT];
                dir_q    <= wdata[B_DIR];
                mode_q   <= wdata[B_MODE];
            end
            if (tx_we) tx_q <= wdata;
            if (go_start) sh_q <= tx_q;
            if (tmr_done) begin
                unique case (st_q)
                    S_XMIT: begin
                        sent_data  <= single_q ? {7'b0, sh_q[0]} : sh_q;
                        sent_valid <= 1'b1;
                    end
                    S_RECV: begin
                        if (dev_answer)
                            rx_q <= single_q ? {7'b0, dev_data[0]} : dev_data;
                    end
                    S_BRK: begin
                        pres_q <= dev_present;
                        init_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ctrl_rd = {single_q, irq_en, ce_q, (st_q != S_IDLE),
                      pres_q, init_q, dir_q, mode_q};

    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE && ctrl_we) |=> $stable({single_q, irq_en, ce_q, dir_q, mode_q}));

    // R6
    brk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BRK && tmr_done) |=> (st_q == S_IDLE && !init_q));

    // R11
    no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && ctrl_we && !wdata[B_CE]) |=> (st_q == S_IDLE));

    // R5
    silent_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RECV && tmr_done && !dev_answer) |=> $stable(rx_q));
endmodule

// File: rtl/swb_istat.sv
module swb_istat (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] set_bits,
    input  logic       rd_clr,
    input  logic       irq_en,
    output logic [2:0] status_q,
    output logic       irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 3'b000;
        else        status_q <= (rd_clr ? 3'b000 : status_q) | set_bits;
    end

    assign irq = irq_en && (status_q != 3'b000);

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && set_bits == 3'b000) |=> (status_q == 3'b000));

    // R8
    keep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != 3'b000) |=> ((status_q & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/swb_regfront.sv
module swb_regfront
    import swb_pkg::*;
#(
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1,
    parameter int         SLOT_CYC  = 4,
    parameter int         BREAK_CYC = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    input  logic       dev_present,
    input  logic       dev_answer,
    input  logic [7:0] dev_data,
    output logic [7:0] sent_data,
    output logic       sent_valid
);
    localparam int LONGEST = (8 * SLOT_CYC > BREAK_CYC) ? 8 * SLOT_CYC : BREAK_CYC;
    localparam int CW      = $clog2(LONGEST + 1);

    logic       ctrl_we, tx_we, rd_clr, irq_en;
    logic [7:0] ctrl_rd, tx_q, rx_q;
    logic [2:0] set_bits, status_q;

    assign ctrl_we = wr_en && (addr == A_CTL);
    assign tx_we   = wr_en && (addr == A_TXD);
    assign rd_clr  = rd_en && (addr == A_IST);

    swb_seq #(
        .SLOT_CYC  (SLOT_CYC),
        .BREAK_CYC (BREAK_CYC),
        .CW        (CW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_we     (ctrl_we),
        .tx_we       (tx_we),
        .wdata       (wdata),
        .dev_present (dev_present),
        .dev_answer  (dev_answer),
        .dev_data    (dev_data),
        .ctrl_rd     (ctrl_rd),
        .tx_q        (tx_q),
        .rx_q        (rx_q),
        .set_bits    (set_bits),
        .sent_data   (sent_data),
        .sent_valid  (sent_valid),
        .irq_en      (irq_en)
    );

    swb_istat u_istat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (set_bits),
        .rd_clr   (rd_clr),
        .irq_en   (irq_en),
        .status_q (status_q),
        .irq      (irq)
    );

    always_comb begin
        case (addr)
            A_REV:   rdata = {REV_MAJOR, REV_MINOR};
            A_TXD:   rdata = tx_q;
            A_RXD:   rdata = rx_q;
            A_CTL:   rdata = ctrl_rd;
            A_IST:   rdata = {5'b0, status_q};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: tb/tb_swb_regfront.sv
module tb_swb_regfront;
    localparam int SLOT = 4;
    localparam int BRK  = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic       dev_present = 1'b0, dev_answer = 1'b0;
    logic [7:0] dev_data = '0;
    logic [7:0] sent_data;
    logic       sent_valid;

    swb_regfront dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq), .dev_present(dev_present),
        .dev_answer(dev_answer), .dev_data(dev_data), .sent_data(sent_data),
        .sent_valid(sent_valid)
    );

    // behavioural reference model
    bit m_sgl, m_ien, m_ce, m_init, m_dir, m_mode, m_pres, m_busy, m_sv;
    int m_left, m_kind;
    logic [7:0] m_txd, m_rxd, m_sh, m_sd;
    logic [2:0] m_ist;

    initial begin
        {m_sgl, m_ien, m_ce, m_init, m_dir, m_mode, m_pres, m_busy, m_sv} = '0;
        m_left = 0; m_kind = 0; m_txd = 0; m_rxd = 0; m_sh = 0; m_sd = 0; m_ist = 0;
    end

    always @(posedge clk) begin : model
        bit b0;
        logic [2:0] setb;
        if (!rst_n) begin
            {m_sgl, m_ien, m_ce, m_init, m_dir, m_mode, m_pres, m_busy, m_sv} = '0;
            m_left = 0; m_txd = 0; m_rxd = 0; m_sd = 0; m_ist = 0;
        end else begin
            b0 = m_busy;
            setb = 3'b000;
            m_sv = 1'b0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 1'b0;
                    if (m_kind == 0) begin
                        m_sd = m_sgl ? {7'b0, m_sh[0]} : m_sh;
                        m_sv = 1'b1;
                        setb = 3'b100;
                    end else if (m_kind == 1) begin
                        if (dev_answer) begin
                            m_rxd = m_sgl ? {7'b0, dev_data[0]} : dev_data;
                            setb = 3'b010;
                        end else setb = 3'b001;
                    end else begin
                        m_pres = dev_present;
                        m_init = 1'b0;
                        setb = 3'b001;
                    end
                end
            end
            if (wr_en && addr == 5'h0C && !b0) begin
                m_sgl = wdata[7]; m_ien = wdata[6]; m_ce = wdata[5];
                m_init = wdata[2]; m_dir = wdata[1]; m_mode = wdata[0];
                if (wdata[4] && wdata[5]) begin
                    m_busy = 1'b1;
                    m_sh = m_txd;
                    m_kind = wdata[2] ? 2 : (wdata[1] ? 1 : 0);
                    m_left = wdata[2] ? BRK : (wdata[7] ? SLOT : 8 * SLOT);
                end
            end
            if (wr_en && addr == 5'h04) m_txd = wdata;
            m_ist = ((rd_en && addr == 5'h10) ? 3'b000 : m_ist) | setb;
        end
    end

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    function automatic logic [7:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00:   return 8'h21;
            5'h04:   return m_txd;
            5'h08:   return m_rxd;
            5'h0C:   return {m_sgl, m_ien, m_ce, m_busy, m_pres, m_init, m_dir, m_mode};
            5'h10:   return {5'b0, m_ist};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit w, input bit r, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1;
        chk("irq", {7'b0, irq}, {7'b0, (m_ien && m_ist != 3'b000)});
        chk("sent_valid", {7'b0, sent_valid}, {7'b0, m_sv});
        if (m_sv) chk("sent_data", sent_data, m_sd);
        if (r) chk("rdata", rdata, exp_rd(a));
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d); cyc(1'b1, 1'b0, a, d); endtask
    task automatic rd(input logic [4:0] a); cyc(1'b0, 1'b1, a, 8'h00); endtask
    task automatic poll(input logic [4:0] a, input int n);
        for (int i = 0; i < n; i++) rd(a);
    endtask

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; rd(5'h04); rd(5'h08); rd(5'h0C); rd(5'h10);
        cur_req = "R2"; rd(5'h00);

        cur_req = "R3"; wr(5'h04, 8'hA5); wr(5'h0C, 8'h60); wr(5'h0C, 8'h70);
        poll(5'h0C, 36);
        cur_req = "R8"; rd(5'h10); rd(5'h10);

        cur_req = "R4"; dev_answer = 1'b1; dev_data = 8'h3C;
        wr(5'h0C, 8'h72); poll(5'h0C, 34); rd(5'h08); rd(5'h10);

        cur_req = "R5"; dev_answer = 1'b0; dev_data = 8'hFF;
        wr(5'h0C, 8'h72); poll(5'h0C, 34); rd(5'h08); rd(5'h10);

        cur_req = "R6"; dev_present = 1'b1;
        wr(5'h0C, 8'h76); poll(5'h0C, 12); rd(5'h10);
        dev_present = 1'b0;
        wr(5'h0C, 8'h74); poll(5'h0C, 12); rd(5'h10);

        cur_req = "R7"; wr(5'h04, 8'hF2); wr(5'h0C, 8'hF0); poll(5'h0C, 6);
        dev_answer = 1'b1; dev_data = 8'h81;
        wr(5'h0C, 8'hF2); poll(5'h0C, 6); rd(5'h08); rd(5'h10);

        cur_req = "R9"; wr(5'h04, 8'h5A); wr(5'h0C, 8'h30); poll(5'h0C, 34);
        wr(5'h0C, 8'h20); rd(5'h0C); wr(5'h0C, 8'h60); rd(5'h0C); rd(5'h10); rd(5'h0C);

        cur_req = "R10"; wr(5'h0C, 8'h70); poll(5'h0C, 3); wr(5'h0C, 8'hF6);
        poll(5'h0C, 34); rd(5'h10);

        cur_req = "R11"; wr(5'h0C, 8'h50); poll(5'h0C, 5); rd(5'h10);

        cur_req = "R8"; wr(5'h04, 8'h3E); wr(5'h0C, 8'h70); poll(5'h10, 36); rd(5'h0C);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule